// File: doc/BRIEF.md
# FIFO-Buffered SPI Master

This block is a serial peripheral interface master driven from a small word-addressed register port. Software programs the shift mode, the word width and the clock divider. It then writes words into a transmit queue. A shift engine moves each queued word out on MOSI, most significant bit first. At the same time it collects the same number of bits from MISO and places the received word in a receive queue, which software drains by reading the data register.

Both queues span a fixed 16 bytes. They therefore hold sixteen 8-bit words, eight 16-bit words or four 32-bit words. The status register reports the fill level of each queue. A receive word that arrives while its queue is full is dropped and raises a sticky overflow flag. The control, status and baud registers can be changed bit by bit through clear and set aliases. An optional automatic slave select keeps SS low for as long as transmit work is pending.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset the control, status and baud registers read 0, SCK and MOSI are 0 and ss_n is 1.
- R2: bus_addr[3:2] selects the register: 0 control, 1 status, 2 data, 3 baud. bus_addr[1:0] selects the access kind: 1 clears the bits written as 1, 2 sets the bits written as 1, and 0 or 3 is a plain write. A word is queued only by a plain write to the data register. Control bits that are not implemented read as 0.
- R3: Control bit 6 gives the SCK idle level. While no word is shifting, SCK equals this bit.
- R4: Control bit 8 selects the edge. When it is 1, the first bit is on MOSI before SCK first leaves its idle level, and MOSI changes on active-to-idle transitions. When it is 0, MOSI changes together with each idle-to-active transition.
- R5: Control bit 9 selects the sample point. When it is 0, MISO is sampled in the middle of each bit's output time. When it is 1, MISO is sampled at the end of that time.
- R6: The 9-bit baud value D makes each SCK half period last D+1 clock cycles.
- R7: Control bits 11:10 set the word width: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 gives 32 bits. Words are sent MSB first. Transmit bits above the width are ignored, and received words read back zero-extended.
- R8: Each queue holds 16, 8 or 4 words for width codes 0, 1 and 2. The status register reports the transmit fill level in bits 20:16 and the receive fill level in bits 28:24.
- R9: A data write while the transmit queue is full is ignored. A data read while the receive queue is empty returns 0.
- R10: Status bit 6 is set when a word completes with the receive queue full. That word is discarded. The bit stays set until a 1 is written to bit 6 at the status clear alias.
- R11: With control bit 28 at 1, ss_n is low while the transmit queue is non-empty or a word is shifting, and it rises after the last word ends. With bit 28 at 0, ss_n stays 1.
- R12: While control bit 15 is 0, both queues are empty, the shift engine is stopped, SCK sits at its idle level and data writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register select [3:2] and access kind [1:0] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
A plain write to the data register can land in the same cycle in which the shift engine pulls the head word out of the transmit queue. The queue must then keep its level and must neither lose nor duplicate a word. The bench provokes this with back-to-back data writes into an idle engine: the second write always coincides with the engine taking the first word. It keeps writing until the queue is full and one more write has been refused. The collision is judged by the transmit level read right after the burst, and by the exact looped-back sequence later found in the receive queue, where exactly one word past its capacity must be dropped and flagged.

// File: rtl/spi_mf_pkg.sv
package spi_mf_pkg;
  // control bit positions
  localparam int CB_CPOL = 6;
  localparam int CB_EDGE = 8;
  localparam int CB_SMP  = 9;
  localparam int CB_WS   = 10;
  localparam int CB_ON   = 15;
  localparam int CB_SSA  = 28;
  localparam logic [31:0] CTRL_MASK = 32'h1000_8F40;

  // status bit positions
  localparam int SB_OVF = 6;
  localparam int SB_TXL = 16;
  localparam int SB_RXL = 24;

  localparam logic [1:0] AL_CLR = 2'd1;
  localparam logic [1:0] AL_SET = 2'd2;

  typedef enum logic [1:0] {
    RG_CTRL = 2'd0,
    RG_STAT = 2'd1,
    RG_DATA = 2'd2,
    RG_BAUD = 2'd3
  } reg_sel_e;

  function automatic logic [31:0] alias_apply(input logic [1:0] kind,
                                              input logic [31:0] cur,
                                              input logic [31:0] wd);
    case (kind)
      AL_CLR:  return cur & ~wd;
      AL_SET:  return cur | wd;
      default: return wd;
    endcase
  endfunction
endpackage

// File: rtl/spi_mf_fifo.sv
module spi_mf_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic [$clog2(DEPTH):0]   cap,
  input  logic                     push,
  input  logic [W-1:0]             din,
  input  logic                     pop,
  output logic [W-1:0]             dout,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     full,
  output logic                     empty
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (level >= cap);
  assign empty   = (level == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spi_mf_shift.sv
module spi_mf_shift #(
  parameter int DIV_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             cpol,
  input  logic             cke,
  input  logic             smp,
  input  logic [1:0]       wsize,
  input  logic [DIV_W-1:0] div,
  input  logic             tx_valid,
  input  logic [31:0]      tx_data,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [31:0]      rx_data,
  output logic             sck,
  output logic             mosi,
  output logic             busy
);
  logic [DIV_W-1:0] cnt;
  logic [5:0]       half, last_half;
  logic [31:0]      shreg, rxsr, rx_next, load_val, rx_word;
  logic             tick, word_end, sample;

  always_comb begin
    case (wsize)
      2'd0: begin
        last_half = 6'd15;
        load_val  = {tx_data[7:0], 24'b0};
      end
      2'd1: begin
        last_half = 6'd31;
        load_val  = {tx_data[15:0], 16'b0};
      end
      default: begin
        last_half = 6'd63;
        load_val  = tx_data;
      end
    endcase
  end

  assign tick     = busy && (cnt == div);
  assign word_end = tick && (half == last_half);
  // even halves end mid-bit, odd halves end at the bit boundary
  assign sample   = (half[0] == smp);
  assign rx_next  = sample ? {rxsr[30:0], miso} : rxsr;
  assign tx_pop   = en && tx_valid && (!busy || word_end);
  assign mosi     = shreg[31];

  always_comb begin
    case (wsize)
      2'd0:    rx_word = {24'b0, rx_next[7:0]};
      2'd1:    rx_word = {16'b0, rx_next[15:0]};
      default: rx_word = rx_next;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy    <= 1'b0;
      cnt     <= '0;
      half    <= '0;
      shreg   <= '0;
      rxsr    <= '0;
      sck     <= cpol;
      rx_push <= 1'b0;
      rx_data <= '0;
    end else begin
      rx_push <= word_end;
      if (word_end) rx_data <= rx_word;
      if (!busy) begin
        if (tx_valid) begin
          busy  <= 1'b1;
          cnt   <= '0;
          half  <= '0;
          shreg <= load_val;
          rxsr  <= '0;
          sck   <= cpol ^ ~cke;
        end else begin
          sck <= cpol;
        end
      end else if (!tick) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        if (word_end) begin
          if (tx_valid) begin
            half  <= '0;
            shreg <= load_val;
            rxsr  <= '0;
            sck   <= cpol ^ ~cke;
          end else begin
            busy  <= 1'b0;
            shreg <= '0;
            rxsr  <= '0;
            sck   <= cpol;
          end
        end else begin
          half <= half + 1'b1;
          rxsr <= rx_next;
          sck  <= ~sck;
          if (half[0]) shreg <= {shreg[30:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master
  import spi_mf_pkg::*;
#(
  parameter int FIFO_BYTES = 16,
  parameter int DIV_W      = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        ss_n
);
  localparam int LVL_W = $clog2(FIFO_BYTES) + 1;

  logic [31:0]      ctrl_q;
  logic [DIV_W-1:0] baud_q;
  logic             ovf_q;
  logic [1:0]       kind, wsz;
  reg_sel_e         rsel;
  logic             on, data_push, rx_pop;
  logic [LVL_W-1:0] cap, tx_lvl, rx_lvl;
  logic [31:0]      tx_dout, rx_dout, rx_word, stat_w;
  logic             tx_full, tx_empty, rx_full, rx_empty;
  logic             tx_pop, rx_push, sh_busy;

  assign rsel      = reg_sel_e'(bus_addr[3:2]);
  assign kind      = bus_addr[1:0];
  assign on        = ctrl_q[CB_ON];
  assign wsz       = (ctrl_q[CB_WS +: 2] == 2'd3) ? 2'd2 : ctrl_q[CB_WS +: 2];
  assign cap       = LVL_W'(FIFO_BYTES >> wsz);
  assign data_push = bus_wr && (rsel == RG_DATA) && (kind != AL_CLR) &&
                     (kind != AL_SET) && on && !tx_full;
  assign rx_pop    = bus_rd && (rsel == RG_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      baud_q <= '0;
    end else if (bus_wr) begin
      if (rsel == RG_CTRL)
        ctrl_q <= alias_apply(kind, ctrl_q, bus_wdata) & CTRL_MASK;
      if (rsel == RG_BAUD)
        baud_q <= DIV_W'(alias_apply(kind, 32'(baud_q), bus_wdata));
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ovf_q <= 1'b0;
    else if (rx_push && rx_full)
      ovf_q <= 1'b1;
    else if (bus_wr && (rsel == RG_STAT) && (kind == AL_CLR) && bus_wdata[SB_OVF])
      ovf_q <= 1'b0;
  end

  spi_mf_fifo #(.DEPTH(FIFO_BYTES), .W(32)) u_txq (
    .clk(clk), .rst(rst), .flush(!on), .cap(cap),
    .push(data_push), .din(bus_wdata), .pop(tx_pop),
    .dout(tx_dout), .level(tx_lvl), .full(tx_full), .empty(tx_empty)
  );

  spi_mf_fifo #(.DEPTH(FIFO_BYTES), .W(32)) u_rxq (
    .clk(clk), .rst(rst), .flush(!on), .cap(cap),
    .push(rx_push), .din(rx_word), .pop(rx_pop),
    .dout(rx_dout), .level(rx_lvl), .full(rx_full), .empty(rx_empty)
  );

  spi_mf_shift #(.DIV_W(DIV_W)) u_shift (
    .clk(clk), .rst(rst), .en(on),
    .cpol(ctrl_q[CB_CPOL]), .cke(ctrl_q[CB_EDGE]), .smp(ctrl_q[CB_SMP]),
    .wsize(wsz), .div(baud_q),
    .tx_valid(!tx_empty), .tx_data(tx_dout), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_word),
    .sck(sck), .mosi(mosi), .busy(sh_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) ss_n <= 1'b1;
    else     ss_n <= ~(ctrl_q[CB_SSA] && on && (sh_busy || !tx_empty));
  end

  always_comb begin
    stat_w                 = '0;
    stat_w[SB_OVF]         = ovf_q;
    stat_w[SB_TXL +: LVL_W] = tx_lvl;
    stat_w[SB_RXL +: LVL_W] = rx_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (rsel)
        RG_CTRL: bus_rdata <= ctrl_q;
        RG_STAT: bus_rdata <= stat_w;
        RG_DATA: bus_rdata <= rx_empty ? 32'd0 : rx_dout;
        default: bus_rdata <= 32'(baud_q);
      endcase
    end
  end
endmodule

// File: rtl/spi_mf_chk.sv
module spi_mf_chk
  import spi_mf_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wr,
  input logic [3:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      ctrl_q,
  input logic [LVL_W-1:0] cap,
  input logic [LVL_W-1:0] tx_lvl,
  input logic [LVL_W-1:0] rx_lvl,
  input logic             tx_pop,
  input logic             rx_push,
  input logic             sh_busy,
  input logic             ovf_q,
  input logic             sck,
  input logic             ss_n
);
  logic on, clr_ovf, data_wr;
  assign on      = ctrl_q[CB_ON];
  assign clr_ovf = bus_wr && (bus_addr == 4'b0101) && bus_wdata[SB_OVF];
  assign data_wr = bus_wr && (bus_addr == 4'b1000);

  // R12: module off flushes queues and parks SCK at idle
  a_r12_off_idle: assert property (@(posedge clk) disable iff (rst)
    !on |=> (sck == $past(ctrl_q[CB_CPOL])) && (tx_lvl == '0) && (rx_lvl == '0));

  // R9: write into a full transmit queue changes nothing
  a_r9_full_write: assert property (@(posedge clk) disable iff (rst)
    (data_wr && on && (tx_lvl >= cap) && !tx_pop) |=> (tx_lvl == $past(tx_lvl)));

  // R10: overflow raised on word arriving at a full receive queue
  a_r10_ovf_set: assert property (@(posedge clk) disable iff (rst)
    (rx_push && (rx_lvl >= cap) && (rx_lvl != '0)) |=> ovf_q);

  // R10: overflow is sticky until cleared through the alias
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !clr_ovf) |=> ovf_q);

  // R11: automatic select active while shifting
  a_r11_ss_active: assert property (@(posedge clk) disable iff (rst)
    (on && ctrl_q[CB_SSA] && sh_busy) |=> !ss_n);

  // R11: select inactive when automatic mode is off
  a_r11_ss_manual: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[CB_SSA] |=> ss_n);
endmodule

bind spi_fifo_master spi_mf_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .cap(cap), .tx_lvl(tx_lvl),
  .rx_lvl(rx_lvl), .tx_pop(tx_pop), .rx_push(rx_push), .sh_busy(sh_busy),
  .ovf_q(ovf_q), .sck(sck), .ss_n(ss_n)
);

// File: tb/spi_fifo_master_bench.sv
module spi_fifo_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        sck, mosi, miso, ss_n;
  logic        use_dly = 1'b0;
  logic [1:0]  dly = 2'b00;
  int          n_chk = 0;
  int          n_err = 0;

  localparam logic [1:0] CTL = 2'd0, STA = 2'd1, DAT = 2'd2, BAU = 2'd3;
  localparam logic [1:0] RAW = 2'd0, CLR = 2'd1, SET = 2'd2;
  localparam logic [31:0] ON = 32'h8000, SSA = 32'h1000_0000;

  always #10 clk = ~clk;

  // delayed loopback: MISO lags MOSI by two cycles (one half period at divider 1)
  always_ff @(posedge clk) dly <= {dly[0], mosi};
  assign miso = use_dly ? dly[1] : mosi;

  spi_fifo_master u_spi_fifo_master (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] r, input logic [1:0] k, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = {r, k}; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] r, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = {r, RAW};
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic burst(input int n, input logic [31:0] base, input logic [31:0] step);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = {DAT, RAW}; bus_wdata = base + step * i;
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(CTL, v); chk("R1 ctrl", v, 0);
    rd(STA, v); chk("R1 status", v, 0);
    rd(BAU, v); chk("R1 baud", v, 0);
    chk("R1 pins", {29'd0, sck, mosi, ss_n}, 32'd1);
  endtask

  task automatic t_alias;
    logic [31:0] v;
    wr(CTL, RAW, 32'h0000_0348); rd(CTL, v); chk("R2 raw masked", v, 32'h340);
    wr(CTL, SET, 32'h0000_0C00); rd(CTL, v); chk("R2 set alias", v, 32'hF40);
    wr(CTL, CLR, 32'h0000_0140); rd(CTL, v); chk("R2 clear alias", v, 32'hE00);
    wr(BAU, RAW, 32'h0000_0FFF); rd(BAU, v); chk("R2 baud width", v, 32'h1FF);
    wr(BAU, CLR, 32'h0000_00F0); rd(BAU, v); chk("R2 baud clear", v, 32'h10F);
    wr(CTL, RAW, 0);
  endtask

  task automatic t_mode(input logic cpol, input logic cke);
    logic [31:0] v;
    logic ps, pm, first, ss_seen, prev_mosi_at, mosi_at;
    int toggles;
    wr(CTL, RAW, ON | SSA | (32'(cpol) << 6) | (32'(cke) << 8));
    wr(BAU, RAW, 1);
    idle(3);
    chk($sformatf("R3 idle cpol=%0d", cpol), {31'd0, sck}, {31'd0, cpol});
    wr(DAT, RAW, 32'hA5);
    ps = sck; pm = mosi; first = 1'b1; ss_seen = 1'b0; toggles = 0;
    prev_mosi_at = 1'b0; mosi_at = 1'b0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (!ss_n) ss_seen = 1'b1;
      if (sck != ps) begin
        toggles++;
        if (first) begin prev_mosi_at = pm; mosi_at = mosi; first = 1'b0; end
      end
      ps = sck; pm = mosi;
    end
    chk($sformatf("R4 edges cpol=%0d cke=%0d", cpol, cke), toggles, 16);
    if (cke) chk("R4 data before first edge", {31'd0, prev_mosi_at}, 1);
    else     chk("R4 data moves with first edge", {30'd0, prev_mosi_at, mosi_at}, 32'd1);
    chk("R3 idle after word", {31'd0, sck}, {31'd0, cpol});
    chk("R11 ss asserted then released", {30'd0, ss_seen, ss_n}, 32'd3);
    rd(DAT, v); chk("R7 8-bit loopback", v, 32'hA5);
  endtask

  task automatic t_baud;
    int c1, c2, n;
    logic ps, ss_low;
    wr(CTL, RAW, ON);
    wr(BAU, RAW, 4);
    wr(DAT, RAW, 32'h3C);
    ps = sck; c1 = -1; c2 = -1; n = 0; ss_low = 1'b0;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (!ss_n) ss_low = 1'b1;
      if (sck != ps) begin
        if (n == 0) c1 = c; else if (n == 1) c2 = c;
        n++;
      end
      ps = sck;
    end
    chk("R6 half period = div+1", c2 - c1, 5);
    chk("R11 ss stays high when manual", {31'd0, ss_low}, 0);
    begin logic [31:0] v; rd(DAT, v); end
  endtask

  task automatic t_width16;
    logic [31:0] v;
    wr(CTL, RAW, ON | (32'd1 << 10));
    wr(BAU, RAW, 1);
    wr(DAT, RAW, 32'h1234_BEEF);
    idle(100);
    rd(DAT, v); chk("R7 16-bit upper bits ignored", v, 32'h0000_BEEF);
  endtask

  task automatic t_sample;
    logic [31:0] v;
    use_dly = 1'b1;
    wr(CTL, RAW, ON | (32'd1 << 10) | (32'd1 << 9) | (32'd1 << 8));
    wr(BAU, RAW, 1);
    wr(DAT, RAW, 32'hC3A5);
    idle(100);
    rd(DAT, v); chk("R5 end-of-bit sample", v, 32'hC3A5);
    wr(CTL, CLR, 32'd1 << 9);
    idle(10);
    wr(DAT, RAW, 32'hC3A5);
    idle(100);
    rd(DAT, v); chk("R5 mid-bit sample", v, 32'h61D2);
    use_dly = 1'b0;
    wr(CTL, RAW, 0);
  endtask

  task automatic t_burst8;
    logic [31:0] v;
    wr(CTL, RAW, ON | SSA);
    wr(BAU, RAW, 3);
    burst(18, 32'h10, 1);
    rd(STA, v); chk("R8 tx level at 8-bit capacity", v, 32'h0010_0000);
    idle(1200);
    rd(STA, v); chk("R10 rx full and overflow", v, 32'h1000_0040);
    for (int i = 0; i < 16; i++) begin
      rd(DAT, v); chk($sformatf("R9 word %0d in order", i), v, 32'h10 + i);
    end
    rd(DAT, v); chk("R9 empty read returns zero", v, 0);
    wr(STA, SET, 0);
    rd(STA, v); chk("R10 overflow sticky", v, 32'h40);
    wr(STA, CLR, 32'h40);
    rd(STA, v); chk("R10 overflow cleared", v, 0);
  endtask

  task automatic t_cap32;
    logic [31:0] v;
    wr(CTL, RAW, ON | (32'd2 << 10));
    wr(BAU, RAW, 1);
    burst(6, 32'hA000_0000, 32'h0101_0101);
    rd(STA, v); chk("R8 tx level at 32-bit capacity", v, 32'h0004_0000);
    idle(800);
    rd(STA, v); chk("R8 rx level at 32-bit capacity", v, 32'h0400_0040);
    for (int i = 0; i < 4; i++) begin
      rd(DAT, v); chk($sformatf("R7 32-bit word %0d", i), v, 32'hA000_0000 + 32'h0101_0101 * i);
    end
    wr(STA, CLR, 32'h40);
  endtask

  task automatic t_off;
    logic [31:0] v;
    wr(CTL, RAW, ON | SSA | 32'h40);
    wr(BAU, RAW, 20);
    burst(3, 32'h77, 0);
    idle(30);
    wr(CTL, CLR, ON);
    idle(1);
    chk("R12 sck idle and ss released", {30'd0, sck, ss_n}, 32'd3);
    rd(STA, v); chk("R12 queues flushed", v, 0);
    wr(DAT, RAW, 32'h55);
    rd(STA, v); chk("R12 data write ignored while off", v, 0);
    wr(CTL, SET, ON);
    idle(100);
    rd(STA, v); chk("R12 nothing shifted after re-enable", v, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_alias;
    t_mode(1'b0, 1'b1);
    t_mode(1'b0, 1'b0);
    t_mode(1'b1, 1'b1);
    t_mode(1'b1, 1'b0);
    t_baud;
    t_width16;
    t_sample;
    t_burst8;
    t_cap32;
    t_off;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule